// File: doc/BRIEF.md
# Two-Phase Pipeline Stage Controller

This block steers one stage of a bundled-data FIFO whose stages talk through transition signalling: every change of level on a handshake wire, rising or falling, is one event. Toward the upstream stage it receives a request (`req_in`) and returns an acknowledge (`ack_in`). Toward the downstream stage it issues a request (`req_out`) and receives an acknowledge (`ack_out`). The stage data register is loaded in the clock cycle in which the block acknowledges upstream. The data is therefore already held when the downstream request is raised.

Two registered C-elements form the control. The left element joins the incoming request with the outgoing request and drives `ack_in`. The right element joins `ack_in` with the downstream acknowledge and drives `req_out`. Both elements start in a state that treats their feedback input as already arrived. As a result, the first incoming request passes straight through to both outputs. A sticky error flag reports two protocol faults: the upstream side requesting twice without an acknowledge, and the downstream side acknowledging when no request is outstanding.

Top module: `pipe_stage_ctl`

## Requirements
- R1: While reset is asserted and right after it, `ack_in`, `req_out`, `err` and `dout` are all 0.
- R2: After reset, the first event on `req_in` toggles `ack_in` at the next clock edge, without any event on `req_out`.
- R3: The first `ack_in` event toggles `req_out` one clock later, without any event on `ack_out`.
- R4: Every later `ack_in` event needs both a new `req_in` event and a `req_out` event since the previous `ack_in` event. While either is missing, `ack_in` holds.
- R5: Every later `req_out` event needs both a new `ack_in` event and an `ack_out` event since the previous `req_out` event. While either is missing, `req_out` holds.
- R6: `cap` is high in exactly the cycles whose closing edge toggles `ack_in`. `dout` takes `din` at that edge and holds at all other edges.
- R7: A `req_in` event that arrives while the previous `req_in` event is still unacknowledged sets `err`.
- R8: An `ack_out` event that arrives while `req_out` has no outstanding event sets `err`.
- R9: Once `err` is set, it stays at 1 until reset.
- R10: Rising and falling changes on `req_in` and `ack_out` count alike as events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Upstream request, transition coded |
| ack_out | input | 1 | Downstream acknowledge, transition coded |
| din | input | WIDTH | Stage data input |
| ack_in | output | 1 | Upstream acknowledge, transition coded |
| req_out | output | 1 | Downstream request, transition coded |
| cap | output | 1 | Capture strobe for the data register |
| dout | output | WIDTH | Stage data register |
| err | output | 1 | Sticky handshake-order error |

## Verification
The bench builds the block with the default `WIDTH` of 8. Each capture carries a distinct byte, so a missed load or a spurious load is visible on `dout`. The stimulus drives the stage into its full state: a `req_in` event is pending while `req_out` waits on `ack_out`. This exposes the join behaviour of both C-elements in both edge polarities. Two separate reset episodes reach each error condition, and the second of them also shows that `err` stays set.

// File: rtl/pipe_stage_ctl.sv
module pipe_stage_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  input  logic             ack_out,
  input  logic [WIDTH-1:0] din,
  output logic             ack_in,
  output logic             req_out,
  output logic             cap,
  output logic [WIDTH-1:0] dout,
  output logic             err
);

  logic req_in_q, ack_out_q;
  logic ack_in_nxt, req_out_nxt;
  logic bad_req, bad_ack;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  assign ack_in_nxt  = maj3(req_in, ack_in, ~req_out);
  assign req_out_nxt = maj3(ack_in, req_out, ~ack_out);
  assign cap         = ack_in_nxt != ack_in;

  assign bad_req = (req_in != req_in_q) && (req_in_q != ack_in);
  assign bad_ack = (ack_out != ack_out_q) && (req_out == ack_out_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_in    <= 1'b0;
      req_out   <= 1'b0;
      req_in_q  <= 1'b0;
      ack_out_q <= 1'b0;
      err       <= 1'b0;
      dout      <= '0;
    end else begin
      ack_in    <= ack_in_nxt;
      req_out   <= req_out_nxt;
      req_in_q  <= req_in;
      ack_out_q <= ack_out;
      err       <= err | bad_req | bad_ack;
      if (cap) dout <= din;
    end
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in != $past(ack_in)) |-> ($past(req_in) == ack_in)); // R4
  AST_ACK_NEEDS_ROUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in != $past(ack_in)) |-> ($past(ack_in) == $past(req_out))); // R4
  AST_ROUT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out != $past(req_out)) |-> ($past(ack_in) != $past(req_out))); // R5
  AST_ROUT_NEEDS_AOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out != $past(req_out)) |-> ($past(ack_out) == $past(req_out))); // R5
  AST_CAP_TOGGLES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (ack_in != $past(ack_in))); // R6
  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(dout)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9

endmodule

// File: tb/pipe_stage_ctl_bench.sv
module pipe_stage_ctl_bench;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, req_in = 0, ack_out = 0;
  logic [W-1:0] din = '0;
  logic ack_in, req_out, cap, err;
  logic [W-1:0] dout;

  typedef struct {
    logic a, r, e;
    logic [W-1:0] d;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipe_stage_ctl #(.WIDTH(W)) u_pipe_stage_ctl (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_out(ack_out), .din(din),
    .ack_in(ack_in), .req_out(req_out), .cap(cap), .dout(dout), .err(err));

  task automatic step(input logic ri, input logic ao, input logic [W-1:0] d,
                      input logic ecap, input logic ea, input logic er,
                      input logic ee, input logic [W-1:0] ed, input string tag);
    exp_t x;
    @(negedge clk);
    req_in = ri; ack_out = ao; din = d;
    #1;
    checks++;
    if (cap !== ecap) begin
      errors++;
      $display("FAIL %s cap: got %0b expected %0b", tag, cap, ecap);
    end
    @(posedge clk); #1;
    x.a = ea; x.r = er; x.e = ee; x.d = ed; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_in = 0; ack_out = 0;
    #1;
    checks++;
    if ({ack_in, req_out, err} !== 3'b000 || dout !== '0) begin
      errors++;
      $display("FAIL R1 reset: got a=%0b r=%0b e=%0b d=%h expected 0 0 0 00",
               ack_in, req_out, err, dout);
    end
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      wait (q.size() != 0);
      x = q.pop_front();
      checks++;
      if (ack_in !== x.a || req_out !== x.r || err !== x.e || dout !== x.d) begin
        errors++;
        $display("FAIL %s: got a=%0b r=%0b e=%0b d=%h expected a=%0b r=%0b e=%0b d=%h",
                 x.tag, ack_in, req_out, err, dout, x.a, x.r, x.e, x.d);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // ri ao din cap a r e dout
    step(1, 0, 8'hA5, 1, 1, 0, 0, 8'hA5, "R2 first req passes, R10 rise");
    step(1, 0, 8'h3C, 0, 1, 1, 0, 8'hA5, "R3 first rout, R6 hold");
    step(0, 0, 8'h11, 1, 0, 1, 0, 8'h11, "R4 ack on fall, R10 fall");
    step(0, 0, 8'h5A, 0, 0, 1, 0, 8'h11, "R5 rout waits ack_out");
    step(1, 0, 8'h22, 0, 0, 1, 0, 8'h11, "R4 full stage blocks ack");
    step(1, 1, 8'h22, 0, 0, 0, 0, 8'h11, "R5 rout after ack_out rise");
    step(1, 1, 8'h22, 1, 1, 0, 0, 8'h22, "R4 ack after rout, R6 load");
    step(1, 1, 8'h77, 0, 1, 0, 0, 8'h22, "R5 rout waits ack_out again");
    step(1, 0, 8'h77, 0, 1, 1, 0, 8'h22, "R5 rout after ack_out fall, R10");
    step(1, 1, 8'h77, 0, 1, 1, 0, 8'h22, "R8 legal ack_out no error");
    step(1, 0, 8'h77, 0, 1, 1, 1, 8'h22, "R8 stray ack_out sets err");
    step(1, 0, 8'h77, 0, 1, 1, 1, 8'h22, "R9 err sticky");
    wait (q.size() == 0);
    do_reset();
    step(1, 0, 8'h01, 1, 1, 0, 0, 8'h01, "R2 after second reset");
    step(1, 0, 8'h02, 0, 1, 1, 0, 8'h01, "R3 after second reset");
    step(0, 0, 8'h03, 1, 0, 1, 0, 8'h03, "R4 second capture");
    step(1, 0, 8'h04, 0, 0, 1, 0, 8'h03, "R7 pending req no error yet");
    step(0, 0, 8'h05, 0, 0, 1, 1, 8'h03, "R7 double req sets err");
    step(0, 0, 8'h06, 0, 0, 1, 1, 8'h03, "R9 err holds");
    wait (q.size() == 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule